// File: doc/BRIEF.md
# Prescaled Countdown Timer with Interrupt

This block is a 32-bit down-counter driven by the peripheral clock. It sits behind a small register bus made of an address, a write strobe, write data and combinational read data. Software writes a start value, then sets a control word. That word turns counting on and off, selects between a single run and automatic restart, gates the interrupt, and holds an 8-bit clock divider. The counter steps down by one every P+1 clock cycles, where P is the divider value.

The counter can reach zero by stepping down from one. When that happens it sets a sticky event flag. Software clears the flag by writing a 1 to it. The interrupt output is a level: it is high while the flag is set and the interrupt enable bit is on. In single-run mode the counter stays at zero. In restart mode, the next tick at zero reloads the counter from the stored start value.

Top module: `prescaled_timer`

## Requirements
- R1: A write to byte offset 0x00 stores the value as the reload value and also places it in the counter, both visible at offset 0x00 and 0x04 from the next cycle. This write has priority over a tick in the same cycle.
- R2: While control bit 0 (enable) is 0, the counter at offset 0x04 holds its value.
- R3: The control word sits at offset 0x08. Bit 0 is enable, bit 1 is auto-reload, bit 2 is interrupt enable, and bits 15:8 are the prescale value P. All other bits read back as 0.
- R4: While enabled, the counter steps down once every P+1 clock cycles. The first step comes P+1 cycles after the write that set enable from 0 to 1, or P+1 cycles after a write to offset 0x00. Either event restarts the prescaler.
- R5: With auto-reload clear, the counter stays at 0 once it reaches 0.
- R6: With auto-reload set, a tick taken while the counter is 0 reloads it from the reload value. A reload value L therefore gives a period of L+1 ticks.
- R7: A step from 1 to 0 sets the event flag, which is bit 0 at offset 0x0C. The interrupt output equals the event flag ANDed with interrupt enable.
- R8: Writing 1 to bit 0 at offset 0x0C clears the event flag, and writing 0 there has no effect. If an event and a clearing write occur in the same cycle, the flag stays set.
- R9: Writes to offset 0x04 are ignored. Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return 0. After reset every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so read data and irq reflect it one cycle later. Read data is combinational, and the bench reads it shortly after a falling edge without waiting another edge. A counter step is due exactly P+1 rising edges after the edge that restarted the prescaler. The bench counts falling edges from the return of each write, and for each prescale value in its sweep it checks the count one edge before each step and again at the step. The event flag and irq rise on the edge where the count reaches 0. The test for a set and a clear in the same cycle places the clearing write on exactly that edge.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int DW    = 32,
  parameter int PSC_W = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] A_LOAD = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h04);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] A_STAT = AW'(8'h0C);
  localparam int PSC_LSB = 8;

  logic [DW-1:0]    load_q, count_q;
  logic [PSC_W-1:0] psc_q, pre_q;
  logic             en_q, rl_q, ie_q, ev_q;

  wire wr_load  = wr_en && addr == A_LOAD;
  wire wr_ctrl  = wr_en && addr == A_CTRL;
  wire wr_stat  = wr_en && addr == A_STAT;
  wire tick     = en_q && pre_q >= psc_q;
  wire hit_zero = tick && !wr_load && count_q == DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      psc_q   <= '0;
      pre_q   <= '0;
      en_q    <= 1'b0;
      rl_q    <= 1'b0;
      ie_q    <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      if (wr_load) begin
        load_q  <= wr_data;
        count_q <= wr_data;
      end else if (tick) begin
        if (count_q != '0) count_q <= count_q - DW'(1);
        else if (rl_q)     count_q <= load_q;
      end

      if (wr_load || tick || !en_q) pre_q <= '0;
      else                          pre_q <= pre_q + PSC_W'(1);

      if (wr_ctrl) begin
        en_q  <= wr_data[0];
        rl_q  <= wr_data[1];
        ie_q  <= wr_data[2];
        psc_q <= wr_data[PSC_LSB +: PSC_W];
      end

      if (hit_zero)                  ev_q <= 1'b1;
      else if (wr_stat && wr_data[0]) ev_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_LOAD: rd_data = load_q;
      A_CNT:  rd_data = count_q;
      A_CTRL: begin
        rd_data[0] = en_q;
        rd_data[1] = rl_q;
        rd_data[2] = ie_q;
        rd_data[PSC_LSB +: PSC_W] = psc_q;
      end
      A_STAT: rd_data[0] = ev_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = ev_q & ie_q;
endmodule

module prescaled_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] count_q,
  input logic          en_q,
  input logic          rl_q,
  input logic          ev_q
);
  wire load_wr  = wr_en && addr == AW'(8'h00);
  wire clear_wr = wr_en && addr == AW'(8'h0C) && wr_data[0];

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_wr) |=> $stable(count_q));

  // R5
  stay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rl_q && count_q == '0 && !load_wr) |=> count_q == '0);

  // R7
  event_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q) |-> count_q == '0);

  // R8
  sticky_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && !clear_wr) |=> ev_q);
endmodule

bind prescaled_timer prescaled_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .count_q(count_q), .en_q(en_q), .rl_q(rl_q), .ev_q(ev_q)
);

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  prescaled_timer dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                       .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int psc_list[6] = '{0, 1, 2, 3, 5, 63};
    logic [31:0] v;
    #(CLK_PERIOD * 2 + 2);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rchk("R9 reset load", 8'h00, 0);
    rchk("R9 reset count", 8'h04, 0);
    rchk("R9 reset ctrl", 8'h08, 0);
    rchk("R9 reset status", 8'h0C, 0);
    chk("R9 reset irq", {31'b0, irq}, 0);

    // R1 / R2
    wr(8'h00, 32'd9);
    rchk("R1 load value", 8'h00, 9);
    rchk("R1 counter loaded", 8'h04, 9);
    edges(20);
    rchk("R2 hold while disabled", 8'h04, 9);

    // R9 count write ignored, unused offsets
    wr(8'h04, 32'd77);
    rchk("R9 count write ignored", 8'h04, 9);
    rchk("R9 load untouched", 8'h00, 9);
    wr(8'h10, 32'hFFFF_FFFF);
    rchk("R9 unused 0x10", 8'h10, 0);
    rchk("R9 unused 0x20", 8'h20, 0);
    rchk("R9 misaligned 0x02", 8'h02, 0);

    // R3 field layout
    wr(8'h08, 32'hFFFF_FFFF);
    rchk("R3 ctrl readback", 8'h08, 32'h0000_FF07);
    wr(8'h08, 32'h0000_2A05);
    rchk("R3 ctrl fields", 8'h08, 32'h0000_2A05);
    wr(8'h08, 0);

    // R4 prescale sweep
    foreach (psc_list[i]) begin
      int p = psc_list[i];
      wr(8'h08, 0);
      wr(8'h00, 32'd4);
      wr(8'h08, (p << 8) | 1);
      for (int k = 1; k <= 3; k++) begin
        edges(p);
        rchk($sformatf("R4 P=%0d before step %0d", p, k), 8'h04, 4 - (k - 1));
        edges(1);
        rchk($sformatf("R4 P=%0d step %0d", p, k), 8'h04, 4 - k);
      end
    end

    // R4 prescaler restarts on load write
    wr(8'h08, 0);
    wr(8'h00, 32'd20);
    wr(8'h08, 32'h0000_0301);
    edges(2);
    wr(8'h00, 32'd10);
    edges(3);
    rchk("R4 restart on load, no step yet", 8'h04, 10);
    edges(1);
    rchk("R4 restart on load, step", 8'h04, 9);

    // R5 / R7 one-shot
    wr(8'h08, 0);
    wr(8'h00, 32'd3);
    wr(8'h0C, 1);
    wr(8'h08, 32'h0000_0001);
    edges(2);
    rchk("R7 count before zero", 8'h04, 1);
    rchk("R7 no event before zero", 8'h0C, 0);
    edges(1);
    rchk("R7 count reaches zero", 8'h04, 0);
    rchk("R7 event set", 8'h0C, 1);
    chk("R7 irq masked", {31'b0, irq}, 0);
    edges(5);
    rchk("R5 stays at zero", 8'h04, 0);
    wr(8'h08, 32'h0000_0005);
    chk("R7 irq when enabled", {31'b0, irq}, 1);

    // R8 write-1-to-clear
    wr(8'h0C, 0);
    rchk("R8 write 0 no effect", 8'h0C, 1);
    chk("R8 irq kept", {31'b0, irq}, 1);
    wr(8'h0C, 1);
    rchk("R8 write 1 clears", 8'h0C, 0);
    chk("R8 irq dropped", {31'b0, irq}, 0);

    // R6 auto-reload, L=2, P=1
    wr(8'h08, 0);
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h0000_0103);
    for (int j = 1; j <= 6; j++) begin
      edges(2);
      rchk($sformatf("R6 tick %0d", j), 8'h04, 2 - (j % 3));
    end
    rchk("R6 event after reload run", 8'h0C, 1);

    // R8 set beats clear in the same cycle
    wr(8'h08, 0);
    wr(8'h00, 32'd1);
    wr(8'h0C, 1);
    rchk("R8 cleared before race", 8'h0C, 0);
    wr(8'h08, 32'h0000_0001);
    wr(8'h0C, 1);
    rchk("R8 race count zero", 8'h04, 0);
    rchk("R8 set wins over clear", 8'h0C, 1);

    // R1 load beats tick
    wr(8'h08, 0);
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h0000_0001);
    wr(8'h00, 32'd30);
    rchk("R1 load wins over tick", 8'h04, 30);

    finish_run();
  end
endmodule